// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block accepts interrupt vectors from on-chip sources over a valid/ready handshake. It stores each vector as a 16-byte record in a circular buffer that lives in external memory. A write pointer, counted in bytes, marks where the next record goes. Software consumes records and reports its progress by writing a read pointer register. When the two pointers are equal, nothing is pending.

Each record is written as four 32-bit memory writes. The write pointer moves only after the fourth write, so software never sees a pointer covering a record that is still being written.

A write that makes the pointers equal again would hide unread data. When detection is enabled, such a write raises a sticky overflow flag inside the write-pointer status word. The record is still written, so the newest vectors are always kept. Optionally, the status word is also copied to a writeback address in memory, so software can poll memory instead of the register.

Top module: `ivr_writer`

## Requirements
- R1: Each accepted vector produces four 32-bit memory writes.
  - The addresses are (BASE << 8) + wptr + 0, 4, 8 and 12, in that order.
  - The data are vector bits [31:0], [63:32], [95:64] and [127:96].
- R2: The write pointer wraps modulo the ring size in bytes, which is 4 << size_log2.
  - It advances by 16 when the fourth data write of a record is accepted, and not before.
  - size_log2 is CTRL bits [12:8]. Values below 3 act as 3, and values above MAX_LOG2 act as MAX_LOG2.
- R3: An advance whose new pointer equals (RPTR masked to the ring) sets the overflow flag.
  - This applies only when overflow detection (CTRL bit 2) is 1.
  - The flag reads as bit 0 of the WPTR register and stays set.
  - The record is still written and the pointer still advances.
- R4: While the overflow-clear bit (CTRL bit 3) is 1, the flag is held at 0. Once the bit returns to 0, detection works again.
- R5: When writeback (CTRL bit 4) is 1, a fifth memory write follows the four data writes.
  - Its address is {WB_HI[7:0], WB_LO[31:0]}.
  - Its data is the updated WPTR status word.
- R6: src_ready is high only when all three of these hold:
  - ring enable (CTRL bit 0) is 1;
  - interrupt enable (CTRL bit 1) is 1;
  - no record is being written.
- R7: busy is high from the cycle after a vector is accepted until the last memory write of that record is accepted. While busy is high, mem_wr_valid is high and the address holds until mem_wr_ready.
- R8: The register port decodes the following offsets:

  | Offset | Register | Behaviour |
  |---|---|---|
  | 0 | CTRL | Control bits as listed in R2 to R6 |
  | 1 | BASE | Address bits [39:8] of the ring base |
  | 2 | RPTR | Software read pointer |
  | 3 | WPTR | A write loads the pointer. A read returns the pointer with the overflow flag in bit 0 |
  | 4 | WB_LO | Low 32 bits of the writeback address |
  | 5 | WB_HI | High 8 bits of the writeback address |

  - Writes take effect at the clock edge. Reads are combinational.
  - Reset clears every register, both pointers and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_valid | input | 1 | Source offers a vector |
| src_ready | output | 1 | Block accepts the vector this cycle |
| src_vec | input | 128 | Interrupt vector, four 32-bit words |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 40 | Byte address of the write |
| mem_wr_data | output | 32 | Write data |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read data |
| busy | output | 1 | A record is being written |

## Verification
The hardest state to reach is an overflow that lands exactly on the read pointer after the ring has wrapped. A close second is the same condition while the clear bit is held. Both need the ring size, the read pointer and a precise number of pushes to line up.

The stimulus table programs small rings with chosen read pointers and pushes counts that wrap once or more. Directed tests then do three things:
- stall the memory to catch the pointer before the advance;
- hold the clear bit through a would-be overflow;
- place the writeback beat after the data beats.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int WORD_W    = 32;
  localparam int VEC_WORDS = 4;
  localparam int VEC_W     = WORD_W * VEC_WORDS;
  localparam int VEC_BYTES = VEC_WORDS * 4;
  localparam int SIZE_W    = 5;
  localparam int MIN_LOG2  = 3;

  typedef struct packed {
    logic [SIZE_W-1:0] size_log2;
    logic              wb_en;
    logic              ovf_clr;
    logic              ovf_det;
    logic              intr_en;
    logic              ring_en;
  } ctrl_t;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_BASE  = 3'd1,
    RA_RPTR  = 3'd2,
    RA_WPTR  = 3'd3,
    RA_WB_LO = 3'd4,
    RA_WB_HI = 3'd5
  } reg_addr_e;

  // Byte mask of the ring for a size given as log2 of 32-bit words.
  function automatic logic [31:0] ring_mask(input logic [SIZE_W-1:0] lg, input int max_lg);
    int e;
    e = int'(lg);
    if (e < MIN_LOG2) e = MIN_LOG2;
    if (e > max_lg) e = max_lg;
    return (32'd4 << e) - 32'd1;
  endfunction

  // Pointer after one record, wrapped into the ring.
  function automatic logic [31:0] ring_step(input logic [31:0] ptr, input logic [31:0] mask);
    return (ptr + 32'(VEC_BYTES)) & mask;
  endfunction
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int ADDR_W = 40,
  parameter int WBHI_W = ADDR_W - 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wr_data,
  input  logic [31:0]       wptr_status,
  output logic [31:0]       reg_rd_data,
  output ctrl_t             ctrl,
  output logic [31:0]       base_q,
  output logic [PTR_W-1:0]  rptr_q,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              wptr_load,
  output logic [PTR_W-1:0]  wptr_load_val
);
  logic [31:0]       wb_lo_q;
  logic [WBHI_W-1:0] wb_hi_q;
  reg_addr_e         ra;

  assign ra = reg_addr_e'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      base_q  <= '0;
      rptr_q  <= '0;
      wb_lo_q <= '0;
      wb_hi_q <= '0;
    end else if (reg_wr_en) begin
      case (ra)
        RA_CTRL: begin
          ctrl.ring_en   <= reg_wr_data[0];
          ctrl.intr_en   <= reg_wr_data[1];
          ctrl.ovf_det   <= reg_wr_data[2];
          ctrl.ovf_clr   <= reg_wr_data[3];
          ctrl.wb_en     <= reg_wr_data[4];
          ctrl.size_log2 <= reg_wr_data[8 +: SIZE_W];
        end
        RA_BASE:  base_q  <= reg_wr_data;
        RA_RPTR:  rptr_q  <= reg_wr_data[PTR_W-1:0];
        RA_WB_LO: wb_lo_q <= reg_wr_data;
        RA_WB_HI: wb_hi_q <= reg_wr_data[WBHI_W-1:0];
        default: ;
      endcase
    end
  end

  assign wptr_load     = reg_wr_en && (ra == RA_WPTR);
  assign wptr_load_val = reg_wr_data[PTR_W-1:0];
  assign wb_addr       = {wb_hi_q, wb_lo_q};

  always_comb begin
    reg_rd_data = '0;
    case (ra)
      RA_CTRL: begin
        reg_rd_data[0]            = ctrl.ring_en;
        reg_rd_data[1]            = ctrl.intr_en;
        reg_rd_data[2]            = ctrl.ovf_det;
        reg_rd_data[3]            = ctrl.ovf_clr;
        reg_rd_data[4]            = ctrl.wb_en;
        reg_rd_data[8 +: SIZE_W]  = ctrl.size_log2;
      end
      RA_BASE:  reg_rd_data = base_q;
      RA_RPTR:  reg_rd_data = 32'(rptr_q);
      RA_WPTR:  reg_rd_data = wptr_status;
      RA_WB_LO: reg_rd_data = wb_lo_q;
      RA_WB_HI: reg_rd_data = 32'(wb_hi_q);
      default:  reg_rd_data = '0;
    endcase
  end

  // R8: a CTRL write is visible in the control outputs on the next cycle
  a_r8_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && ra == RA_CTRL) |=> (ctrl.ring_en == $past(reg_wr_data[0])));
endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr
  import ivr_pkg::*;
#(
  parameter int PTR_W    = 16,
  parameter int MAX_LOG2 = PTR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] size_log2,
  input  logic              ovf_det,
  input  logic              ovf_clr,
  input  logic [PTR_W-1:0]  rptr,
  input  logic              commit,
  input  logic              load,
  input  logic [PTR_W-1:0]  load_val,
  output logic [PTR_W-1:0]  wptr,
  output logic              ovf,
  output logic [31:0]       wptr_status
);
  logic [PTR_W-1:0] mask;
  logic [PTR_W-1:0] nxt;
  logic             hit_rptr;

  assign mask     = PTR_W'(ring_mask(size_log2, MAX_LOG2));
  assign nxt      = PTR_W'(ring_step(32'(wptr), 32'(mask)));
  assign hit_rptr = (nxt == (rptr & mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
    end else if (load) begin
      wptr <= load_val & mask & ~PTR_W'(VEC_BYTES - 1);
    end else if (commit) begin
      wptr <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
    end else if (ovf_clr) begin
      ovf <= 1'b0;
    end else if (commit && !load && ovf_det && hit_rptr) begin
      ovf <= 1'b1;
    end
  end

  assign wptr_status = 32'(wptr) | {31'b0, ovf};

  // R4: the clear bit wins over any overflow
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> !ovf);
  // R3: the flag is sticky until cleared
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  // R2: every commit moves the pointer (the ring holds at least two records)
  a_r2_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !load) |=> (wptr != $past(wptr)));
  // R2: the pointer stays on record boundaries
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wptr[3:0] == 4'd0);
endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
  import ivr_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VEC_W-1:0]  vec,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [31:0]       wptr_status,
  input  logic              mem_wr_ready,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic              commit,
  output logic              busy
);
  localparam int BEAT_W  = 3;
  localparam int LAST_DW = VEC_WORDS - 1;

  logic              busy_q;
  logic [BEAT_W-1:0] beat_q;
  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wba_q;
  logic              wb_q;
  logic              fire;
  logic              done;
  logic              wb_beat;
  logic [31:0]       words [VEC_WORDS];

  for (genvar g = 0; g < VEC_WORDS; g++) begin : g_word
    assign words[g] = vec_q[g*WORD_W +: WORD_W];
  end

  assign fire    = busy_q && mem_wr_ready;
  assign wb_beat = (beat_q == BEAT_W'(VEC_WORDS));
  assign commit  = fire && (beat_q == BEAT_W'(LAST_DW));
  assign done    = fire && (wb_beat || (commit && !wb_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      vec_q  <= '0;
      addr_q <= '0;
      wba_q  <= '0;
      wb_q   <= 1'b0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      beat_q <= '0;
      vec_q  <= vec;
      addr_q <= slot_addr;
      wba_q  <= wb_addr;
      wb_q   <= wb_en;
    end else if (done) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (fire) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign mem_wr_valid = busy_q;
  assign busy         = busy_q;
  assign mem_wr_addr  = wb_beat ? wba_q : addr_q + ADDR_W'({beat_q, 2'b00});
  assign mem_wr_data  = wb_beat ? wptr_status : words[beat_q[1:0]];

  // R1: the first beat goes to the slot captured at acceptance
  a_r1_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> (mem_wr_valid && mem_wr_addr == $past(slot_addr)));
  // R1: data beats step by one word
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && beat_q < BEAT_W'(LAST_DW)) |=> (mem_wr_addr == $past(mem_wr_addr) + ADDR_W'(4)));
  // R7: a stalled request holds its address
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr)));
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int MAX_LOG2   = 14,
  parameter int ADDR_W     = 40,
  parameter int BASE_SHIFT = 8,
  localparam int PTR_W     = MAX_LOG2 + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [VEC_W-1:0]  src_vec,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wr_data,
  output logic [31:0]       reg_rd_data,
  output logic              busy
);
  ctrl_t             ctrl;
  logic [31:0]       base_q;
  logic [PTR_W-1:0]  rptr_q;
  logic [ADDR_W-1:0] wb_addr;
  logic              wptr_load;
  logic [PTR_W-1:0]  wptr_load_val;
  logic [PTR_W-1:0]  wptr;
  logic              ovf;
  logic [31:0]       wptr_status;
  logic              commit;
  logic              seq_busy;
  logic              accept;
  logic [ADDR_W-1:0] slot_addr;

  ivr_regs #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .reg_wr_en, .reg_addr, .reg_wr_data, .wptr_status,
    .reg_rd_data, .ctrl, .base_q, .rptr_q, .wb_addr, .wptr_load, .wptr_load_val
  );

  ivr_ptr #(.PTR_W(PTR_W), .MAX_LOG2(MAX_LOG2)) u_ptr (
    .clk, .rst_n, .size_log2(ctrl.size_log2), .ovf_det(ctrl.ovf_det),
    .ovf_clr(ctrl.ovf_clr), .rptr(rptr_q), .commit, .load(wptr_load),
    .load_val(wptr_load_val), .wptr, .ovf, .wptr_status
  );

  assign src_ready = ctrl.ring_en && ctrl.intr_en && !seq_busy;
  assign accept    = src_valid && src_ready;
  assign slot_addr = (ADDR_W'(base_q) << BASE_SHIFT) + ADDR_W'(wptr);

  ivr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .start(accept), .vec(src_vec), .slot_addr,
    .wb_en(ctrl.wb_en), .wb_addr, .wptr_status, .mem_wr_ready,
    .mem_wr_valid, .mem_wr_addr, .mem_wr_data, .commit, .busy(seq_busy)
  );

  assign busy = seq_busy;

  // R6: no second vector is taken while the first is being written
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !src_ready);
  // R7: accepted work shows as busy on the next cycle
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R3: overflow only rises on a commit
  a_r3_rise_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(commit));
endmodule

// File: tb/ivr_writer_bench.sv
module ivr_writer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         src_valid = 1'b0;
  logic         src_ready;
  logic [127:0] src_vec = '0;
  logic         mem_wr_valid;
  logic         mem_wr_ready = 1'b1;
  logic [39:0]  mem_wr_addr;
  logic [31:0]  mem_wr_data;
  logic         reg_wr_en = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wr_data = '0;
  logic [31:0]  reg_rd_data;
  logic         busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [39:0] log_a [32];
  logic [31:0] log_d [32];
  int          log_n = 0;

  always #5 clk = ~clk;

  ivr_writer u_ivr_writer (
    .clk, .rst_n, .src_valid, .src_ready, .src_vec, .mem_wr_valid, .mem_wr_ready,
    .mem_wr_addr, .mem_wr_data, .reg_wr_en, .reg_addr, .reg_wr_data, .reg_rd_data, .busy
  );

  // memory model: records each handshake that will complete at the next edge
  always @(negedge clk) begin
    #1;
    if (mem_wr_valid && mem_wr_ready && log_n < 32) begin
      log_a[log_n] = mem_wr_addr;
      log_d[log_n] = mem_wr_data;
      log_n = log_n + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rd_data;
  endtask

  task automatic push(input logic [127:0] v);
    @(negedge clk);
    src_vec = v; src_valid = 1'b1;
    while (!src_ready) @(negedge clk);
    @(negedge clk);
    src_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // CTRL bit values (R8): 0 ring, 1 intr, 2 detect, 3 clear, 4 writeback, [12:8] size
  function automatic logic [31:0] ctrl_word(input bit ring, input bit intr, input bit det,
                                            input bit clr, input bit wb, input logic [4:0] lg);
    return {19'b0, lg, 3'b0, wb, clr, det, intr, ring};
  endfunction

  typedef struct packed {
    logic [4:0]  lg;
    logic        det;
    logic [15:0] rptr;
    logic [7:0]  npush;
    logic [31:0] exp_status;
  } row_t;

  localparam int ROWS = 9;
  localparam row_t TBL [ROWS] = '{
    '{5'd4, 1'b1, 16'd0,  8'd2, 32'h20},
    '{5'd4, 1'b1, 16'd0,  8'd4, 32'h01},
    '{5'd4, 1'b1, 16'd32, 8'd1, 32'h10},
    '{5'd4, 1'b1, 16'd32, 8'd2, 32'h21},
    '{5'd5, 1'b1, 16'd0,  8'd5, 32'h50},
    '{5'd4, 1'b1, 16'd16, 8'd6, 32'h21},
    '{5'd3, 1'b1, 16'd0,  8'd3, 32'h11},
    '{5'd4, 1'b0, 16'd0,  8'd4, 32'h00},
    '{5'd2, 1'b1, 16'd0,  8'd3, 32'h11}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    rd(3'd3, r); check("R8 reset wptr", 64'(r), 64'h0);
    rd(3'd0, r); check("R8 reset ctrl", 64'(r), 64'h0);
    check("R6 reset ready", 64'(src_ready), 64'h0);
    check("R7 reset busy", 64'(busy), 64'h0);

    // table: R2 wrap, R3 overflow, clamp of size
    for (int i = 0; i < ROWS; i++) begin
      wr(3'd0, ctrl_word(0, 0, 0, 1, 0, 5'd0));
      wr(3'd2, 32'(TBL[i].rptr));
      wr(3'd3, 32'h0);
      wr(3'd0, ctrl_word(1, 1, TBL[i].det, 0, 0, TBL[i].lg));
      for (int k = 0; k < int'(TBL[i].npush); k++) push({4{32'(k + i * 16)}});
      rd(3'd3, r);
      check($sformatf("R2/R3 row %0d", i), 64'(r), 64'(TBL[i].exp_status));
    end

    // R1 and R5: beat addresses and data, then writeback
    wr(3'd0, ctrl_word(0, 0, 0, 1, 0, 5'd0));
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h0012_3456);
    wr(3'd4, 32'h0000_1000);
    wr(3'd5, 32'h0000_00AB);
    wr(3'd0, ctrl_word(1, 1, 1, 0, 1, 5'd4));
    log_n = 0;
    push({32'hD3D3_0003, 32'hC2C2_0002, 32'hB1B1_0001, 32'hA0A0_0000});
    check("R1 beat count with R5", 64'(log_n), 64'd5);
    check("R1 addr0", 64'(log_a[0]), 64'h12_3456_00);
    check("R1 data0", 64'(log_d[0]), 64'hA0A0_0000);
    check("R1 addr3", 64'(log_a[3]), 64'h12_3456_0C);
    check("R1 data3", 64'(log_d[3]), 64'hD3D3_0003);
    check("R5 wb addr", 64'(log_a[4]), 64'hAB_0000_1000);
    check("R5 wb data", 64'(log_d[4]), 64'h10);

    // R7 / R2: stalled memory; pointer moves only after the fourth data write
    mem_wr_ready = 1'b0;
    @(negedge clk);
    src_vec = {4{32'h5555_AAAA}}; src_valid = 1'b1;
    @(negedge clk);
    src_valid = 1'b0;
    check("R6 ready low while writing", 64'(src_ready), 64'h0);
    check("R7 busy during stall", 64'(busy), 64'h1);
    check("R7 valid during stall", 64'(mem_wr_valid), 64'h1);
    check("R1 stalled addr", 64'(mem_wr_addr), 64'h12_3456_10);
    repeat (3) @(negedge clk);
    rd(3'd3, r); check("R2 no advance before data done", 64'(r), 64'h10);
    mem_wr_ready = 1'b1;
    while (busy) @(negedge clk);
    rd(3'd3, r); check("R2 advance after data", 64'(r), 64'h20);
    check("R7 busy drops", 64'(busy), 64'h0);

    // R6: interrupt enable off blocks acceptance
    wr(3'd0, ctrl_word(1, 0, 1, 0, 1, 5'd4));
    log_n = 0;
    @(negedge clk);
    src_valid = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 ready low with intr off", 64'(src_ready), 64'h0);
    src_valid = 1'b0;
    rd(3'd3, r); check("R6 no write with intr off", 64'(r), 64'h20);
    check("R6 no memory traffic", 64'(log_n), 64'd0);

    // R4: clear bit held through a would-be overflow, then detection resumes
    wr(3'd0, ctrl_word(0, 0, 0, 1, 0, 5'd0));
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h0);
    wr(3'd0, ctrl_word(1, 1, 1, 1, 0, 5'd4));
    for (int k = 0; k < 4; k++) push({4{32'(k)}});
    rd(3'd3, r); check("R4 flag held clear", 64'(r), 64'h0);
    wr(3'd0, ctrl_word(1, 1, 1, 0, 0, 5'd4));
    for (int k = 0; k < 4; k++) push({4{32'(k)}});
    rd(3'd3, r); check("R4 detection resumes (R3 set)", 64'(r), 64'h01);
    push('0);
    rd(3'd3, r); check("R3 sticky after more writes", 64'(r), 64'h11);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule